// File: doc/BRIEF.md
# Segment LCD Common-Phase Timing Generator

This block produces the time-multiplexed common timing for a small segment LCD. An 8-bit control register, written and read through a plain synchronous port, picks the number of common lines (the duty ratio), the phase rate and blanking. It also holds two static configuration bits, which are passed straight out to the supply and pin logic.

While running, the block steps an active common index through the selected number of commons. It drives one strobe per common and flips a polarity output once per frame, so the panel sees no net DC bias. A one-cycle pulse marks the start of each frame. A blank flag tells the segment drivers to force every segment off.

The duty field also serves as the run enable. Code 00 holds all counters at zero and keeps every strobe low. Each phase lasts a power-of-two number of clock cycles, so one frame lasts that many cycles times the number of commons. Any write that alters the duty or rate field restarts the phase at the edge where the write lands.

Top module: `lcd_frame_timer`

## Requirements
- R1: The register reads back exactly what was last written. Bit 7 is a reserved bit, bit 6 is the port-select bit, bit 5 is the internal-divider bit, bit 4 is the blank bit, bits 3:2 are the duty field and bits 1:0 are the rate field. After reset the register reads 8'h10.
- R2: While the duty field is 00, the common index stays 0, all strobes stay low, no frame-start pulse occurs and the polarity output holds its value.
- R3: Each common phase lasts 2^(PRESC_BASE + rate) clock cycles, counted from the write that set the mode.
- R4: For duty codes 01, 10 and 11 the number of commons is N = code + 1. The common index runs 0, 1, …, N-1 and then returns to 0.
- R5: While running, exactly one strobe is high, namely strobe bit number common-index. No more than one strobe is ever high.
- R6: Each time the index wraps from N-1 to 0, the polarity output toggles and the frame-start output is high for exactly that one cycle. One frame therefore spans N phases.
- R7: The blank output equals the blank bit (bit 4). 1 means all segments are off.
- R8: The internal-divider output follows bit 5 and the port-select output follows bit 6.
- R9: A write that changes the duty or rate field resets the phase counter and the common index at the clock edge that stores the write. A full phase at the new setting then follows.
- R10: A write that leaves the duty and rate fields unchanged does not disturb the running phase timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register contents |
| com_idx | output | 2 | Active common index |
| com_strobe | output | 4 | One strobe per common line |
| frame_pol | output | 1 | Drive polarity, toggles each frame |
| frame_start | output | 1 | One-cycle pulse at each frame start |
| blank | output | 1 | Segments forced off when high |
| cfg_int_div | output | 1 | Internal divider selected |
| cfg_port_sel | output | 1 | Supply pins handed over to port use |

## Verification
The phase length is measured for every rate code under each of the three running duty codes. This separates a prescaler that ignores the rate field from one that wrongly scales with the duty field. A run at duty 10 over several frames checks the index order, the one-hot strobe, the polarity flip and the single-cycle frame pulse at the three-common wrap point, which differs from a power-of-two wrap. Two writes are made in the middle of a phase: one changes only the rate and one toggles only the blank bit. Comparing the remaining phase lengths shows a restart in the first case and no restart in the second. A stopped run checks that the outputs stay quiet.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int MAX_COMMONS = 4;
    localparam int IDX_W       = $clog2(MAX_COMMONS);

    typedef enum logic [1:0] {
        DUTY_STOP  = 2'b00,
        DUTY_HALF  = 2'b01,
        DUTY_THIRD = 2'b10,
        DUTY_QUART = 2'b11
    } duty_e;

    typedef struct packed {
        logic       resv;
        logic       port_sel;
        logic       int_div;
        logic       blank;
        duty_e      duty;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{resv: 1'b0, port_sel: 1'b0, int_div: 1'b0,
                                     blank: 1'b1, duty: DUTY_STOP, rate: 2'b00};

    // index of the last common for a running duty code (N-1)
    function automatic logic [IDX_W-1:0] last_common(input duty_e d);
        return IDX_W'(d);
    endfunction

endpackage

// File: rtl/lcdt_ctrl_reg.sv
module lcdt_ctrl_reg
    import lcdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl,
    output logic       restart
);
    ctrl_t ctrl_q;
    ctrl_t wr_val;

    assign wr_val  = ctrl_t'(wr_data);
    assign restart = wr_en && ((wr_val.duty != ctrl_q.duty) || (wr_val.rate != ctrl_q.rate));
    assign ctrl    = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= CTRL_RESET;
        else if (wr_en) ctrl_q <= wr_val;
    end
endmodule

// File: rtl/lcdt_prescaler.sv
module lcdt_prescaler #(
    parameter int PRESC_BASE = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       phase_tick
);
    localparam int CW = PRESC_BASE + 4;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit      = (CW'(1) << (PRESC_BASE + int'(rate))) - CW'(1);
    assign phase_tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || phase_tick) cnt_q <= '0;
        else                                      cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/lcdt_phase_seq.sv
module lcdt_phase_seq
    import lcdt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic                   restart,
    input  duty_e                  duty,
    input  logic                   phase_tick,
    output logic [IDX_W-1:0]       idx,
    output logic [MAX_COMMONS-1:0] strobe,
    output logic                   pol,
    output logic                   fstart
);
    logic [IDX_W-1:0] idx_q;
    logic             pol_q;
    logic             fs_q;
    logic             wrap;

    assign wrap = phase_tick && (idx_q == last_common(duty));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            pol_q <= 1'b0;
            fs_q  <= 1'b0;
        end else if (restart || !run) begin
            idx_q <= '0;
            fs_q  <= 1'b0;
        end else if (phase_tick) begin
            idx_q <= wrap ? '0 : idx_q + IDX_W'(1);
            pol_q <= wrap ? ~pol_q : pol_q;
            fs_q  <= wrap;
        end else begin
            fs_q  <= 1'b0;
        end
    end

    for (genvar c = 0; c < MAX_COMMONS; c++) begin : g_strobe
        assign strobe[c] = run && (idx_q == IDX_W'(c));
    end

    assign idx    = idx_q;
    assign pol    = pol_q;
    assign fstart = fs_q;
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcdt_pkg::*;
#(
    parameter int PRESC_BASE = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    output logic [IDX_W-1:0]       com_idx,
    output logic [MAX_COMMONS-1:0] com_strobe,
    output logic                   frame_pol,
    output logic                   frame_start,
    output logic                   blank,
    output logic                   cfg_int_div,
    output logic                   cfg_port_sel
);
    ctrl_t ctrl;
    logic  restart;
    logic  run;
    logic  phase_tick;

    lcdt_ctrl_reg u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl(ctrl), .restart(restart)
    );

    assign run = (ctrl.duty != DUTY_STOP);

    lcdt_prescaler #(.PRESC_BASE(PRESC_BASE)) u_presc (
        .clk(clk), .rst(rst), .run(run), .restart(restart),
        .rate(ctrl.rate), .phase_tick(phase_tick)
    );

    lcdt_phase_seq u_seq (
        .clk(clk), .rst(rst), .run(run), .restart(restart), .duty(ctrl.duty),
        .phase_tick(phase_tick), .idx(com_idx), .strobe(com_strobe),
        .pol(frame_pol), .fstart(frame_start)
    );

    assign rd_data      = 8'(ctrl);
    assign blank        = ctrl.blank;
    assign cfg_int_div  = ctrl.int_div;
    assign cfg_port_sel = ctrl.port_sel;
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker
    import lcdt_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [7:0]             rd_data,
    input logic [IDX_W-1:0]       com_idx,
    input logic [MAX_COMMONS-1:0] com_strobe,
    input logic                   frame_pol,
    input logic                   frame_start
);
    // R5: never more than one common strobed
    a_r5_strobe_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_strobe));

    // R2: stopped mode keeps strobes low and no frame pulse
    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3:2] == 2'b00) |-> (com_strobe == '0 && !frame_start));

    // R4: index never exceeds N-1
    a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
        com_idx <= IDX_W'(rd_data[3:2]));

    // R6: frame pulse accompanies a polarity flip
    a_r6_pol_flip: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (frame_pol != $past(frame_pol)));

    // R6: polarity changes only with a frame pulse
    a_r6_flip_needs_start: assert property (@(posedge clk) disable iff (rst)
        (frame_pol != $past(frame_pol)) |-> frame_start);

    // R6: frame pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);
endmodule

bind lcd_frame_timer lcdt_checker chk_i (
    .clk(clk), .rst(rst), .rd_data(rd_data), .com_idx(com_idx),
    .com_strobe(com_strobe), .frame_pol(frame_pol), .frame_start(frame_start)
);

// File: tb/lcd_frame_timer_tb_top.sv
module lcd_frame_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] com_idx;
    logic [3:0] com_strobe;
    logic       frame_pol, frame_start, blank, cfg_int_div, cfg_port_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_frame_timer #(.PRESC_BASE(BASE)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .com_idx(com_idx), .com_strobe(com_strobe), .frame_pol(frame_pol),
        .frame_start(frame_start), .blank(blank), .cfg_int_div(cfg_int_div),
        .cfg_port_sel(cfg_port_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write lands
    task automatic write_reg(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // cycles remaining until com_idx leaves its current value
    task automatic measure_phase(output int len);
        logic [1:0] start;
        start = com_idx;
        len = 0;
        while (com_idx == start && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1 reset value", rd_data, 8'h10);
        check("R7 reset blank", blank, 1);
        check("R2 reset strobes", com_strobe, 0);
        check("R2 reset idx", com_idx, 0);
        check("R6 reset pol", frame_pol, 0);
    endtask

    task automatic t_readback;
        write_reg(8'hA6);
        check("R1 readback A6", rd_data, 8'hA6);
        write_reg(8'h5B);
        check("R1 readback 5B", rd_data, 8'h5B);
    endtask

    task automatic t_cfg_blank;
        write_reg(8'h60);
        check("R8 int_div", cfg_int_div, 1);
        check("R8 port_sel", cfg_port_sel, 1);
        check("R7 blank off", blank, 0);
        write_reg(8'h30);
        check("R8 int_div only", cfg_int_div, 1);
        check("R8 port_sel clear", cfg_port_sel, 0);
        check("R7 blank on", blank, 1);
    endtask

    task automatic t_stop;
        int bad = 0;
        logic p0;
        write_reg(8'h00);
        p0 = frame_pol;
        for (int i = 0; i < 80; i++) begin
            if (com_idx != 0 || com_strobe != 0 || frame_start || frame_pol != p0) bad++;
            @(negedge clk);
        end
        check("R2 stopped outputs quiet", bad, 0);
    endtask

    task automatic t_phase_lengths;
        int len;
        write_reg(8'h00);
        for (int m = 1; m < 4; m++) begin
            for (int f = 0; f < 4; f++) begin
                write_reg(8'((m << 2) | f));
                measure_phase(len);
                check($sformatf("R3 phase len duty %0d rate %0d", m, f), len, 1 << (BASE + f));
            end
        end
    endtask

    task automatic t_sequence;
        int l = 1 << BASE;
        logic p0;
        write_reg(8'h08);  // duty 10 -> three commons, rate 0
        p0 = frame_pol;
        for (int p = 0; p < 8; p++) begin
            check($sformatf("R4 idx phase %0d", p), com_idx, p % 3);
            check($sformatf("R5 strobe phase %0d", p), com_strobe, 1 << (p % 3));
            check($sformatf("R6 pol phase %0d", p), frame_pol, p0 ^ ((p / 3) % 2));
            check($sformatf("R6 fstart phase %0d", p), frame_start, (p % 3 == 0 && p > 0) ? 1 : 0);
            @(negedge clk);
            check($sformatf("R6 fstart low after phase %0d start", p), frame_start, 0);
            repeat (l - 1) @(negedge clk);
        end
    endtask

    task automatic t_restart;
        int len;
        write_reg(8'h0D);  // four commons, rate 1 -> 8 cycles
        repeat (3) @(negedge clk);
        write_reg(8'h0E);  // rate change mid phase
        measure_phase(len);
        check("R9 restart gives full phase", len, 1 << (BASE + 2));
        write_reg(8'h0D);
        repeat (3) @(negedge clk);
        write_reg(8'h1D);  // only blank bit flips
        measure_phase(len);
        check("R10 no restart remaining phase", len, (1 << (BASE + 1)) - 4);
        check("R10 idx after phase", com_idx, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_cfg_blank();
        t_stop();
        t_phase_lengths();
        t_sequence();
        t_restart();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule